// File: doc/BRIEF.md
# SPI Slave Register-Access Port

This block is the serial front end of a sensor-style register bank. An external master selects it with an active-low chip select, clocks it with SCK and sends commands on MOSI. The block answers on MISO. Every access is one fixed 16-clock frame. The command byte names a 6-bit register address, a read/write flag and a mandatory zero bit. The byte that follows carries either the value to write or the register contents being returned.

The serial pins are brought into the system clock domain through synchronizers, and both SCK edges are detected there. Inside, the frame decoder talks to a small register bank over a parallel bus that carries an address, write data and a one-cycle write strobe. During the command byte, MISO carries a power-on status flag. The flag is set by reset and cleared by the first frame that completes. Frames that are malformed or cut short are dropped without side effects. The SCK half period must be at least four system clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: The bus uses SPI mode 0. MOSI is sampled on rising SCK edges, MSB first. Frame bits 1 to 6 are address A5..A0, bit 7 is the operation (1 = write, 0 = read), bit 8 must be 0 and bits 9 to 16 are write data D7..D0.
- R2: A write frame that completes (16 rising edges, bit 8 zero) updates the addressed register. The internal write strobe is high for exactly one system clock cycle, and only at the end of such a frame.
- R3: In a read frame, MISO carries the addressed register during bits 9 to 16, MSB first. MISO changes after falling SCK edges, so each bit is valid at the rising edge that follows.
- R4: During the command byte, MISO is 0 for bits 1 to 6 and bit 8. For bit 7 it carries the power-on status flag, which reset sets to 1.
- R5: The status flag clears when the first frame completes (16 rising edges with bit 8 zero) and stays clear until the next reset. Aborted frames leave it set.
- R6: If bit 8 is 1, the frame is aborted. No register is written, MISO reads 0 for bits 9 to 16 and the status flag is kept.
- R7: If the chip select rises before the 16th rising SCK edge, the frame is dropped and no register is written.
- R8: The MISO enable is 1 only while the chip select is low. While the enable is 0, MISO is 0. After reset the enable is 0.
- R9: Address 0 is a read-only identifier, 0x5A by default. Addresses 1 to NUM_REGS-1 (default 7) are read/write and reset to 0x00. Addresses from NUM_REGS up to 63 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from the master, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | High while MISO should be driven onto the bus |

## Verification
The assertions check these rules on every cycle:
- the write strobe lasts exactly one cycle;
- the write strobe fires only inside a selected, completed frame;
- the status flag, once cleared, never sets again, and a completed frame clears it;
- MISO is quiet whenever its enable is low, and the enable drops after the chip select rises.

Only the bench scenarios can show the serial contents:
- the address and data bit order;
- the position of the status bit;
- the register map, including the read-only identifier and addresses that do not alias;
- that aborted and truncated frames leave the registers and the flag untouched.

// File: rtl/spi_reg_pkg.sv
// Package: frame geometry and shared constants of the SPI register port.
// Assumes a fixed 16-bit frame: 8 command bits followed by 8 data bits.
package spi_reg_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int CMD_BITS   = ADDR_W + 2;
    localparam int FRAME_BITS = CMD_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    // 1-based frame bit positions
    localparam int RW_POS     = ADDR_W + 1;
    localparam int ZERO_POS   = ADDR_W + 2;
    localparam int STAT_POS   = ADDR_W + 1;
endpackage

// File: rtl/spi_sync.sv
// Module: multi-stage synchronizer for asynchronous serial pins.
// Assumes the inputs are slow relative to clk; each bit is resampled independently.
module spi_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Purpose: shift the pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
// Module: SPI mode-0 frame decoder and MISO serializer.
// Works on synchronized pins; expects each SCK half period to last four or more clk cycles.
// Produces a parallel register bus (address, write data, write strobe) and a
// completion pulse for frames with 16 rising edges and a zero in bit 8.
module spi_frame
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              porst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              frame_done,
    output logic              miso,
    output logic              miso_oe
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_RW   = CNT_W'(RW_POS - 1);
    localparam logic [CNT_W-1:0] CNT_ZERO = CNT_W'(ZERO_POS - 1);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] CNT_STAT = CNT_W'(STAT_POS);

    logic              sck_d, cs_d;
    logic              sck_rise, sck_fall, cs_fall;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-2:0] sh_in;
    logic [DATA_W-1:0] sh_out;
    logic              rw_q, zero_bad_q;

    // Purpose: remember previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
    assign sck_fall = ~sck_s & sck_d & ~cs_n_s;
    assign cs_fall  = ~cs_n_s & cs_d;

    // Purpose: count bits, capture command fields and issue bus strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            sh_in      <= '0;
            bus_addr   <= '0;
            bus_wdata  <= '0;
            rw_q       <= 1'b0;
            zero_bad_q <= 1'b0;
            bus_wr     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            bus_wr     <= 1'b0;
            frame_done <= 1'b0;
            if (cs_n_s || cs_fall) begin
                cnt <= '0;
            end else if (sck_rise && cnt != CNT_FULL) begin
                cnt   <= cnt + 1'b1;
                sh_in <= {sh_in[DATA_W-3:0], mosi_s};
                if (cnt == CNT_ADDR) bus_addr   <= {sh_in[ADDR_W-2:0], mosi_s};
                if (cnt == CNT_RW)   rw_q       <= mosi_s;
                if (cnt == CNT_ZERO) zero_bad_q <= mosi_s;
                if (cnt == CNT_LAST && !zero_bad_q) begin
                    frame_done <= 1'b1;
                    if (rw_q) begin
                        bus_wr    <= 1'b1;
                        bus_wdata <= {sh_in, mosi_s};
                    end
                end
            end
        end
    end

    // Purpose: drive MISO after falling edges and gate its enable with select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso    <= 1'b0;
            miso_oe <= 1'b0;
            sh_out  <= '0;
        end else if (cs_n_s) begin
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= 1'b1;
            if (cs_fall) begin
                miso <= (CNT_STAT == CNT_W'(1)) ? porst : 1'b0;
            end else if (sck_fall && cnt != '0 && cnt != CNT_FULL) begin
                if (cnt < CNT_CMD) begin
                    miso <= ((cnt + 1'b1) == CNT_STAT) ? porst : 1'b0;
                end else if (cnt == CNT_CMD) begin
                    sh_out <= zero_bad_q ? '0 : rd_data;
                    miso   <= zero_bad_q ? 1'b0 : rd_data[DATA_W-1];
                end else begin
                    sh_out <= {sh_out[DATA_W-2:0], 1'b0};
                    miso   <= sh_out[DATA_W-2];
                end
            end
        end
    end
endmodule

// File: rtl/spi_regbank.sv
// Module: small register bank behind the parallel bus, plus the power-on flag.
// Address 0 is a read-only identifier; unmapped addresses read zero.
// Assumes NUM_REGS <= 2**ADDR_W.
module spi_regbank
    import spi_reg_pkg::*;
#(
    parameter int               NUM_REGS = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              frame_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              porst
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_id
            assign regs[i] = ID_VALUE;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            // Purpose: hold one writable register.
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(i)) q <= bus_wdata;
            end
            assign regs[i] = q;
        end
    end

    // Purpose: select the addressed register, zero when unmapped.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (bus_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    // Purpose: power-on flag, set by reset and cleared by a completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          porst <= 1'b1;
        else if (frame_done) porst <= 1'b0;
    end
endmodule

// File: rtl/spi_reg_slave.sv
// Module: top of the SPI slave register port.
// Chain: pin synchronizers, then frame decoder, then register bank.
// Assumes the SCK half period spans four or more clk cycles.
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int               NUM_REGS    = 8,
    parameter logic [DATA_W-1:0] ID_VALUE    = 8'h5A,
    parameter int               SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic              cs_n_s, sck_s, mosi_s;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, rd_data;
    logic              bus_wr, frame_done, porst;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sck, spi_mosi}),
        .q({cs_n_s, sck_s, mosi_s})
    );

    spi_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .sck_s(sck_s), .mosi_s(mosi_s),
        .rd_data(rd_data), .porst(porst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .frame_done(frame_done),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    spi_regbank #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .frame_done(frame_done),
        .rd_data(rd_data), .porst(porst)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Module: protocol checker bound into spi_reg_slave.
module spi_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_s,
    input logic bus_wr,
    input logic frame_done,
    input logic porst,
    input logic miso,
    input logic miso_oe
);
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);
    p_strobe_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> frame_done);
    p_strobe_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !cs_n_s);
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !porst |=> !porst);
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !porst);
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso);
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso_oe);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .bus_wr(bus_wr),
    .frame_done(frame_done), .porst(porst),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
);

// File: tb/test_spi_reg_slave.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8 * CLK_PERIOD;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    int   n_tests = 0, n_fail = 0;
    logic [7:0] cmd_rx, dat_rx;
    logic       oe_mid;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs nbits SCK cycles of a frame and collects MISO bits before each rise.
    task automatic xfer(input logic [5:0] a, input logic rw, input logic zb,
                        input logic [7:0] d, input int nbits);
        logic [15:0] vec = {a, rw, zb, d};
        logic [15:0] rx  = '0;
        spi_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = vec[15-i];
            #HALF_SCK;
            rx[15-i] = spi_miso;
            if (i == 0) oe_mid = spi_miso_oe;
            spi_sck = 1'b1;
            #HALF_SCK;
            spi_sck = 1'b0;
        end
        #HALF_SCK;
        spi_cs_n = 1'b1;
        #(2*HALF_SCK);
        cmd_rx = rx[15:8];
        dat_rx = rx[7:0];
    endtask

    task automatic t_reset;
        check("R8 oe after reset", {7'd0, spi_miso_oe}, 8'h00);
        check("R8 miso after reset", {7'd0, spi_miso}, 8'h00);
    endtask

    task automatic t_aborts;
        xfer(6'd2, 1'b1, 1'b0, 8'h3C, 12);              // truncated write
        xfer(6'd2, 1'b1, 1'b1, 8'h3C, 16);              // bad zero bit
        check("R4 status bit set after reset", cmd_rx, 8'h02);
        check("R6 data phase zero on abort", dat_rx, 8'h00);
        xfer(6'd2, 1'b0, 1'b0, 8'h00, 16);
        check("R5 flag kept after aborts", cmd_rx, 8'h02);
        check("R6 R7 aborted writes ignored", dat_rx, 8'h00);
        check("R8 oe during frame", {7'd0, oe_mid}, 8'h01);
        check("R8 oe after frame", {7'd0, spi_miso_oe}, 8'h00);
    endtask

    task automatic t_status_clear;
        xfer(6'd0, 1'b0, 1'b0, 8'h00, 16);
        check("R5 flag cleared", cmd_rx, 8'h00);
        check("R9 R3 identifier", dat_rx, 8'h5A);
    endtask

    task automatic t_write_read;
        xfer(6'd3, 1'b1, 1'b0, 8'hA5, 16);
        xfer(6'd5, 1'b1, 1'b0, 8'h3C, 16);
        xfer(6'd6, 1'b1, 1'b0, 8'hC3, 16);
        xfer(6'd7, 1'b1, 1'b0, 8'h81, 16);
        xfer(6'd3, 1'b0, 1'b0, 8'h00, 16);
        check("R1 R2 R3 reg3", dat_rx, 8'hA5);
        check("R4 command bits quiet", cmd_rx, 8'h00);
        xfer(6'd5, 1'b0, 1'b0, 8'h00, 16);
        check("R2 reg5", dat_rx, 8'h3C);
        xfer(6'd6, 1'b0, 1'b0, 8'h00, 16);
        check("R2 reg6", dat_rx, 8'hC3);
        xfer(6'd7, 1'b0, 1'b0, 8'h00, 16);
        check("R9 last register", dat_rx, 8'h81);
    endtask

    task automatic t_map;
        xfer(6'd0, 1'b1, 1'b0, 8'hFF, 16);
        xfer(6'd0, 1'b0, 1'b0, 8'h00, 16);
        check("R9 identifier read-only", dat_rx, 8'h5A);
        xfer(6'd41, 1'b1, 1'b0, 8'h77, 16);
        xfer(6'd41, 1'b0, 1'b0, 8'h00, 16);
        check("R9 unmapped reads zero", dat_rx, 8'h00);
        xfer(6'd1, 1'b0, 1'b0, 8'h00, 16);
        check("R9 no aliasing to reg1", dat_rx, 8'h00);
        check("R5 flag stays clear", cmd_rx, 8'h00);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_PERIOD/2);
        t_reset();
        t_aborts();
        t_status_clear();
        t_write_read();
        t_map();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule